// File: doc/BRIEF.md
# Software CPU Reset Pulse Generator

This block lets software reset the processor without going through the keyboard controller. A host writes a one-bit reset request into a control register. After a fixed delay the block drives an internal active-low reset strobe low for a fixed width. The strobe is then ANDed with the keyboard controller's active-low reset, which first passes through a two-flop synchroniser, and the result drives a single reset pin. A configuration input sets the polarity of that pin.

The delay and the width are given in nanoseconds. They are turned into cycle counts from the clock frequency and always rounded up, so the minimum times hold at any clock rate. A global enable input gates the whole software path. While the enable is low, writes are dropped, reads return 0, any sequence in progress is stopped, and the pin follows only the keyboard path. Once a sequence has been accepted, the request bit has to be written back to 0 before another sequence can start.

Top module: `cpu_swreset_gen`

## Requirements
- R1: With `port_en` high, a write sets the request bit to the value of `reg_wdat`, and a read (`reg_sel` high) returns that bit on `reg_rdat`.
- R2: A write of 1 that is accepted while the bit is 0 and no sequence is running makes `alt_rst_n` go low exactly DLY_CYC = ceil(CLK_HZ·DELAY_NS/1e9) cycles after the write edge. This is 1750 cycles at 125 MHz with a 14000 ns delay.
- R3: `alt_rst_n` then stays low for exactly WID_CYC = ceil(CLK_HZ·WIDTH_NS/1e9) cycles, which is 750 at 125 MHz with 6000 ns, and then returns high.
- R4: While the bit is still 1, a further write of 1 does not start or extend a pulse. No new pulse can occur until the bit has been written to 0.
- R5: A write of 1 made while a sequence is still running, after the bit was cleared, is ignored. The bit reads 0 and no second pulse follows.
- R6: Writing 0 during a pulse clears the bit but does not shorten the pulse.
- R7: While `port_en` is low, writes are ignored, reads return 0, `alt_rst_n` is held high, and a running sequence is dropped and does not resume when `port_en` returns high.
- R8: `kbc_rst_n` reaches the pin through a two-flop synchroniser. A change is visible on `rst_out` two clock edges after it is applied.
- R9: The pin carries the AND of the two active-low sources. It is inverted (active-high) when `pol_hi` is 1 and passed unchanged (active-low) when `pol_hi` is 0.
- R10: After reset, the request bit is 0, `alt_rst_n` is high and `rst_out` is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| reg_sel | input | 1 | Control register selected |
| reg_wr | input | 1 | Write strobe, valid with `reg_sel` |
| reg_wdat | input | 1 | Write value of the request bit |
| reg_rdat | output | 1 | Read value of the request bit |
| port_en | input | 1 | Global enable for the software reset path |
| pol_hi | input | 1 | 1 = active-high pin, 0 = active-low pin |
| kbc_rst_n | input | 1 | Asynchronous active-low keyboard controller reset |
| alt_rst_n | output | 1 | Software reset strobe, active low, gated by enable |
| rst_out | output | 1 | Combined reset pin after the polarity setting |

## Verification
Taking the write edge as cycle W, `alt_rst_n` must still be high at W+DLY_CYC−1, low from W+DLY_CYC through W+DLY_CYC+WID_CYC−1, and high again at W+DLY_CYC+WID_CYC. A keyboard reset change shows on the pin at cycle c+2 and not at c+1. Reads, the polarity setting and the enable gating act combinationally within the same cycle. The driver stores each expected value in a queue together with the cycle it is due. A monitor samples away from the clock edge and compares each item only in its exact cycle, so a result that arrives one cycle early or late fails.

// File: rtl/cpu_swreset_gen.sv
module cpu_swreset_gen #(
  parameter int unsigned CLK_HZ   = 125_000_000,
  parameter int unsigned DELAY_NS = 14_000,
  parameter int unsigned WIDTH_NS = 6_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reg_sel,
  input  logic reg_wr,
  input  logic reg_wdat,
  output logic reg_rdat,
  input  logic port_en,
  input  logic pol_hi,
  input  logic kbc_rst_n,
  output logic alt_rst_n,
  output logic rst_out
);
  localparam int unsigned DLY_CYC =
    int'((64'(CLK_HZ) * 64'(DELAY_NS) + 64'd999_999_999) / 64'd1_000_000_000);
  localparam int unsigned WID_CYC =
    int'((64'(CLK_HZ) * 64'(WIDTH_NS) + 64'd999_999_999) / 64'd1_000_000_000);
  localparam int unsigned MAX_CYC = (DLY_CYC > WID_CYC) ? DLY_CYC : WID_CYC;
  localparam int CW = $clog2(MAX_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_LOW} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          req;
  logic [1:0]    ksync;
  logic          wr_hit;
  logic          comb_n;

  assign wr_hit = reg_sel && reg_wr && port_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req   <= 1'b0;
      st    <= S_IDLE;
      cnt   <= '0;
      ksync <= 2'b11;
    end else begin
      ksync <= {ksync[0], kbc_rst_n};
      if (!port_en) begin
        st  <= S_IDLE;
        cnt <= '0;
      end else begin
        if (wr_hit) begin
          if (!reg_wdat) begin
            req <= 1'b0;
          end else if (!req && st == S_IDLE) begin
            req <= 1'b1;
            st  <= S_WAIT;
            cnt <= '0;
          end
        end
        case (st)
          S_WAIT:
            if (cnt == CW'(DLY_CYC - 1)) begin
              st  <= S_LOW;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          S_LOW:
            if (cnt == CW'(WID_CYC - 1)) begin
              st  <= S_IDLE;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          default: ;
        endcase
      end
    end
  end

  assign alt_rst_n = !((st == S_LOW) && port_en);
  assign comb_n    = ksync[1] & alt_rst_n;
  assign rst_out   = pol_hi ? !comb_n : comb_n;
  assign reg_rdat  = reg_sel && port_en && req;

endmodule

module cpu_swreset_gen_chk #(
  parameter int unsigned DLY_CYC = 1,
  parameter int unsigned WID_CYC = 1
) (
  input logic clk,
  input logic rst_n,
  input logic reg_sel,
  input logic reg_wr,
  input logic reg_wdat,
  input logic reg_rdat,
  input logic port_en,
  input logic req,
  input logic alt_rst_n
);
  int unsigned low_len;
  int unsigned since_req;
  logic        req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_len   <= 0;
      since_req <= 0;
      req_q     <= 1'b0;
    end else begin
      req_q     <= req;
      low_len   <= alt_rst_n ? 0 : low_len + 1;
      if (req && !req_q)              since_req <= 1;
      else if (since_req != 32'hFFFF_FFFF) since_req <= since_req + 1;
    end
  end

  // R2
  delay_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alt_rst_n) |-> since_req == DLY_CYC);

  // R3
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(alt_rst_n) && port_en) |-> low_len == WID_CYC);

  // R1
  wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && reg_wr && port_en && !reg_wdat) |=> !req);

  // R7
  dis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> $stable(req));

  // R7
  dis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alt_rst_n |-> port_en);

  // R7
  always_comb begin
    if (rst_n && !port_en && reg_sel)
      dis_read_chk: assert (!reg_rdat);
  end
endmodule

bind cpu_swreset_gen cpu_swreset_gen_chk #(.DLY_CYC(DLY_CYC), .WID_CYC(WID_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdat(reg_wdat),
  .reg_rdat(reg_rdat), .port_en(port_en), .req(req), .alt_rst_n(alt_rst_n)
);

// File: tb/cpu_swreset_gen_tb.sv
`timescale 1ns/1ps
module cpu_swreset_gen_tb;
  localparam int unsigned CLK_HZ = 125_000_000;
  localparam int D = int'((64'(CLK_HZ) * 64'd14_000 + 64'd999_999_999) / 64'd1_000_000_000);
  localparam int L = int'((64'(CLK_HZ) * 64'd6_000 + 64'd999_999_999) / 64'd1_000_000_000);

  logic clk = 1'b0;
  logic rst_n, reg_sel, reg_wr, reg_wdat, port_en, pol_hi, kbc_rst_n;
  logic reg_rdat, alt_rst_n, rst_out;

  cpu_swreset_gen #(.CLK_HZ(CLK_HZ), .DELAY_NS(14_000), .WIDTH_NS(6_000)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdat(reg_wdat),
    .reg_rdat(reg_rdat), .port_en(port_en), .pol_hi(pol_hi), .kbc_rst_n(kbc_rst_n),
    .alt_rst_n(alt_rst_n), .rst_out(rst_out)
  );

  always #4 clk = ~clk;

  typedef struct {
    int    due;
    bit    is_pin;
    bit    val;
    string tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input bit act, input bit exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cyc=%0d actual=%b expected=%b", tag, cyc, act, exp);
    end
  endtask

  task automatic push(input int due, input bit is_pin, input bit val, input string tag);
    item_t it;
    it.due = due; it.is_pin = is_pin; it.val = val; it.tag = tag;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    #2;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        chk(q[i].tag, q[i].is_pin ? rst_out : alt_rst_n, q[i].val);
        q.delete(i);
      end
    end
  end

  task automatic wr(input bit d, output int w);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_wdat = d;
    @(negedge clk);
    w = cyc;
    reg_sel = 1'b0; reg_wr = 1'b0; reg_wdat = 1'b0;
  endtask

  task automatic rd(input bit exp, input string tag);
    reg_sel = 1'b1;
    #1 chk(tag, reg_rdat, exp);
    reg_sel = 1'b0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(200_000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog cyc=%0d actual=running expected=finished", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int w, w2, w3, w4, w5, w6, w7, x, c;
    rst_n = 1'b0; reg_sel = 1'b0; reg_wr = 1'b0; reg_wdat = 1'b0;
    port_en = 1'b1; pol_hi = 1'b0; kbc_rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 rst_out", rst_out, 1'b1);
    chk("R10 alt_rst_n", alt_rst_n, 1'b1);
    rd(1'b0, "R10 bit0");
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3: basic sequence
    wr(1'b1, w);
    rd(1'b1, "R1 set readback");
    push(w + D - 1, 0, 1'b1, "R2 still high");
    push(w + D, 0, 1'b0, "R2 low at delay");
    push(w + D, 1, 1'b0, "R9 pin low");
    push(w + D + L - 1, 0, 1'b0, "R3 still low");
    push(w + D + L, 0, 1'b1, "R3 released");
    wait_until(w + 100);
    wr(1'b1, x);
    wait_until(w + D + L + 5);

    // R4: bit still 1, no new pulse
    wr(1'b1, w2);
    push(w2 + D, 0, 1'b1, "R4 no pulse");
    push(w2 + D + 10, 0, 1'b1, "R4 no pulse later");
    wait_until(w2 + D + 20);

    // R1 clear, R6 no shortening, R5 rewrite during run
    wr(1'b0, x);
    rd(1'b0, "R1 clear readback");
    wr(1'b1, w3);
    wait_until(w3 + D + 10);
    wr(1'b0, x);
    rd(1'b0, "R6 cleared mid pulse");
    wr(1'b1, w4);
    rd(1'b0, "R5 write ignored");
    push(w3 + D + L - 1, 0, 1'b0, "R6 pulse kept");
    push(w3 + D + L, 0, 1'b1, "R6 pulse end");
    push(w4 + D, 0, 1'b1, "R5 no second pulse");
    wait_until(w4 + D + 5);

    // R8 synchroniser, R9 polarity
    c = cyc; kbc_rst_n = 1'b0;
    push(c + 1, 1, 1'b1, "R8 not yet");
    push(c + 2, 1, 1'b0, "R8 kbc through");
    wait_until(c + 4);
    c = cyc; kbc_rst_n = 1'b1;
    push(c + 2, 1, 1'b1, "R8 kbc release");
    wait_until(c + 4);
    pol_hi = 1'b1;
    #1 chk("R9 idle active-high", rst_out, 1'b0);
    c = cyc; kbc_rst_n = 1'b0;
    push(c + 2, 1, 1'b1, "R9 asserted high");
    wait_until(c + 4);
    kbc_rst_n = 1'b1;
    wait_until(cyc + 3);
    pol_hi = 1'b0;

    // R7 disabled
    @(negedge clk);
    port_en = 1'b0;
    wr(1'b1, w5);
    rd(1'b0, "R7 read while disabled");
    push(w5 + D, 0, 1'b1, "R7 no pulse disabled");
    wait_until(w5 + D + 5);
    port_en = 1'b1;
    rd(1'b0, "R7 write was ignored");

    // R7 abort
    wr(1'b1, w6);
    wait_until(w6 + D + 5);
    chk("R2 low before abort", alt_rst_n, 1'b0);
    port_en = 1'b0;
    #1 chk("R7 gated high", alt_rst_n, 1'b1);
    repeat (2) @(negedge clk);
    port_en = 1'b1;
    #1 chk("R7 aborted stays high", alt_rst_n, 1'b1);
    rd(1'b1, "R7 bit kept");
    @(negedge clk);
    wr(1'b0, x);
    wr(1'b1, w7);
    push(w7 + D, 0, 1'b0, "R2 pulse after rearm");
    push(w7 + D + L, 0, 1'b1, "R3 end after rearm");
    wait_until(w7 + D + L + 5);

    n_chk++;
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R2 pending=%0d expected=0", q.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule